// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block collects one-clock request pulses from a fixed set of interrupt sources and keeps each one as a pending bit. Software gives every source a priority level from 1 to 3, or turns it off. The block picks a single winning source and presents its index to the CPU together with a valid flag. The CPU then takes that request through a one-cycle acknowledge input.

Some sources are fixed to the top level as traps. A parameter mask lists them. They ignore their programmed priority and the global enable. Any acknowledge, a disable strobe, or a write of 0 turns the global enable off. Software must write it back to 1 before ordinary sources can be served again.

Software reaches the block through a small register bus with four word addresses:

| Address | Contents |
|---|---|
| 0 | Pending requests |
| 1 | Upper priority bits |
| 2 | Lower priority bits |
| 3 | Global enable, in bit 0 |

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every pending bit is 0, every priority is disabled, the global enable reads 0 and vecValid is 0. Address 0 is the pending register, address 1 holds the upper priority bits, address 2 holds the lower priority bits, and address 3 holds the global enable in bit 0.
- R2: A pulse of one clock on srcPulse[i] sets pending bit i on that clock edge. The bit stays set after the pulse ends. This also happens when source i is disabled.
- R3: The level of source i is {upper[i], lower[i]}. The value 00 means disabled, 01 means level 1, 10 means level 2 and 11 means level 3. A disabled, non-trap source never becomes the winner.
- R4: Any eligible level-3 request beats every level-2 request. Any level-2 request beats every level-1 request.
- R5: When several eligible requests share the same level, the one with the lowest source index wins.
- R6: A source in TRAP_MASK behaves as level 3 whatever its programmed bits are. It is eligible even when the global enable is 0.
- R7: A non-trap request can only drive vecValid while the global enable is 1. vecValid is raised one clock after an eligible request is seen as pending.
- R8: An acknowledge while vecValid is 1 clears the pending bit at vecIndex. It also clears the global enable on the same edge.
- R9: A write to address 0 loads the whole pending register. Writing 0 erases a request that has not been serviced yet.
- R10: A new pulse on a bit wins over a clear of that same bit in the same cycle, whether the clear comes from a register write or from an acknowledge.
- R11: Writing 1 to the global enable sets it. Writing 0 clears it, and so does a pulse on diStrobe.
- R12: While vecValid is 1 and no acknowledge arrives, vecIndex does not change, even if a request of higher priority comes in. vecValid drops one clock after the held source stops being eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | NUM_SRC | One-clock request pulses, one per source |
| regAddr | input | 2 | Register word address |
| regWr | input | 1 | Register write strobe |
| regWdata | input | NUM_SRC | Register write data |
| regRdata | output | NUM_SRC | Register read data for regAddr (combinational) |
| diStrobe | input | 1 | Disable-interrupts command strobe |
| ack | input | 1 | CPU acknowledge of the presented vector |
| vecValid | output | 1 | A winning request is being presented |
| vecIndex | output | $clog2(NUM_SRC) | Index of the winning source |

## Verification
A fault in the pending register shows up at address 0 on the clock right after the pulse or clear. It also shows up as a missing or extra vecValid one clock later. A wrong level decode or a wrong tie-break shows up as a wrong vecIndex on the first presentation after the requests land. The sweep over every pair of non-trap sources at every pair of levels catches it there. A global enable that fails to clear after an acknowledge or a disable strobe reads back wrong at address 3 on the very next clock. A winner that is not held shows up as a changing vecIndex within one clock of a higher-level pulse.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PEND = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRIO_HI = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRIO_LO = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_GCTRL = 2'd3;

  typedef struct packed {
    logic pendWr;
    logic hiWr;
    logic loWr;
    logic ackClr;
    logic gieSet;
    logic gieClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_prio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic                  wdataBit0,
  input  logic                  diStrobe,
  input  logic                  ack,
  input  logic                  vecValid,
  output ctrlStrobes_t          strobes,
  output logic                  gie
);
  logic ctrlWr;

  always_comb begin
    ctrlWr          = regWr && (regAddr == ADDR_GCTRL);
    strobes.pendWr  = regWr && (regAddr == ADDR_PEND);
    strobes.hiWr    = regWr && (regAddr == ADDR_PRIO_HI);
    strobes.loWr    = regWr && (regAddr == ADDR_PRIO_LO);
    strobes.ackClr  = ack && vecValid;
    strobes.gieSet  = ctrlWr && wdataBit0;
    strobes.gieClr  = diStrobe || (ack && vecValid) || (ctrlWr && !wdataBit0);
  end

  // The clear wins over the set.
  always_ff @(posedge clk) begin
    if (!rstN)               gie <= 1'b0;
    else if (strobes.gieClr) gie <= 1'b0;
    else if (strobes.gieSet) gie <= 1'b1;
  end

  // R8
  ack_drops_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && vecValid) |=> !gie);

  // R11
  di_drops_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    diStrobe |=> !gie);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] TRAP_MASK = 1,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_SRC-1:0]    regWdata,
  input  logic [NUM_SRC-1:0]    srcPulse,
  input  logic                  gie,
  output logic [NUM_SRC-1:0]    regRdata,
  output logic                  vecValid,
  output logic [IDX_W-1:0]      vecIndex
);
  logic [NUM_SRC-1:0] pend, pendNext;
  logic [NUM_SRC-1:0] prioHi, prioLo;
  logic [NUM_SRC-1:0] elig;
  logic [1:0]         effLvl [NUM_SRC];
  logic               found;
  logic [IDX_W-1:0]   winIdx;

  // Pending register: a pulse sets the bit and wins over any clear.
  always_comb begin
    pendNext = strobes.pendWr ? regWdata : pend;
    if (strobes.ackClr) pendNext[vecIndex] = 1'b0;
    pendNext = pendNext | srcPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= '0;
      prioHi <= '0;
      prioLo <= '0;
    end else begin
      pend <= pendNext;
      if (strobes.hiWr) prioHi <= regWdata;
      if (strobes.loWr) prioLo <= regWdata;
    end
  end

  // Effective level and eligibility of each source.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (TRAP_MASK[i]) begin : g_trap
      assign effLvl[i] = 2'b11;
      assign elig[i]   = pend[i];
    end else begin : g_norm
      assign effLvl[i] = {prioHi[i], prioLo[i]};
      assign elig[i]   = pend[i] && (effLvl[i] != 2'b00) && gie;
    end
  end

  // Highest level first, then the lowest index within that level.
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int lv = 3; lv >= 1; lv--) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (!found && elig[i] && (effLvl[i] == 2'(lv))) begin
          found  = 1'b1;
          winIdx = IDX_W'(i);
        end
      end
    end
  end

  // The winner is held until it is acknowledged or stops being eligible.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecIndex <= '0;
    end else if (vecValid) begin
      if (strobes.ackClr || !elig[vecIndex]) vecValid <= 1'b0;
    end else begin
      vecValid <= found;
      vecIndex <= winIdx;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_PEND:    regRdata = pend;
      ADDR_PRIO_HI: regRdata = prioHi;
      ADDR_PRIO_LO: regRdata = prioLo;
      default:      regRdata = {{(NUM_SRC-1){1'b0}}, gie};
    endcase
  end

  // R2
  pulse_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcPulse != '0) |=> ((pend & $past(srcPulse)) == $past(srcPulse)));

  // R12
  index_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !strobes.ackClr) |=> (!vecValid || (vecIndex == $past(vecIndex))));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackClr && !srcPulse[vecIndex]) |=> !pend[$past(vecIndex)]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] TRAP_MASK = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcPulse,
  input  logic [1:0]                 regAddr,
  input  logic                       regWr,
  input  logic [NUM_SRC-1:0]         regWdata,
  output logic [NUM_SRC-1:0]         regRdata,
  input  logic                       diStrobe,
  input  logic                       ack,
  output logic                       vecValid,
  output logic [$clog2(NUM_SRC)-1:0] vecIndex
);
  ctrlStrobes_t strobes;
  logic         gie;

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .wdataBit0(regWdata[0]), .diStrobe(diStrobe), .ack(ack),
    .vecValid(vecValid), .strobes(strobes), .gie(gie)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .TRAP_MASK(TRAP_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .regWdata(regWdata), .srcPulse(srcPulse), .gie(gie),
    .regRdata(regRdata), .vecValid(vecValid), .vecIndex(vecIndex)
  );
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcPulse = '0;
  logic [1:0]   regAddr = '0;
  logic         regWr = 1'b0;
  logic [N-1:0] regWdata = '0;
  logic [N-1:0] regRdata;
  logic         diStrobe = 1'b0;
  logic         ack = 1'b0;
  logic         vecValid;
  logic [2:0]   vecIndex;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N), .TRAP_MASK(8'h01)) dut_i (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .diStrobe(diStrobe), .ack(ack), .vecValid(vecValid), .vecIndex(vecIndex)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    cyc(1);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    srcPulse = m; cyc(1); srcPulse = '0;
  endtask

  task automatic doAck();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  initial begin
    logic [N-1:0] r;
    cyc(3); rstN = 1'b1; cyc(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk(r == 0, "R1 reg reset", int'(r), 0);
    end
    chk(vecValid == 0, "R1 valid reset", int'(vecValid), 0);

    // R2 R3: a disabled source latches its request but never wins
    wr(3, 8'h01);
    pulse(8'h10); cyc(2);
    rd(0, r);
    chk(r == 8'h10, "R2 sticky pend", int'(r), 8'h10);
    chk(vecValid == 0, "R3 disabled no win", int'(vecValid), 0);
    wr(0, 8'h00); cyc(2);

    // R3 R4 R5: every pair of non-trap sources at every pair of levels
    for (int i = 1; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        for (int la = 0; la < 4; la++) begin
          for (int lb = 0; lb < 4; lb++) begin
            logic [N-1:0] hi, lo;
            int expIdx;
            bit expV;
            hi = '0; lo = '0;
            hi[i] = la[1]; lo[i] = la[0]; hi[j] = lb[1]; lo[j] = lb[0];
            wr(1, hi); wr(2, lo);
            pulse((N'(1) << i) | (N'(1) << j)); cyc(2);
            expV = (la != 0) || (lb != 0);
            expIdx = (la >= lb && la != 0) ? i : j;
            chk(vecValid == expV, "R4 sweep valid", int'(vecValid), int'(expV));
            if (expV)
              chk(vecIndex == 3'(expIdx), "R5 sweep index", int'(vecIndex), expIdx);
            wr(0, 8'h00); cyc(2);
          end
        end
      end
    end

    // R7: the global enable gates non-trap sources
    wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'h00);
    pulse(8'h04); cyc(2);
    chk(vecValid == 0, "R7 gie off blocks", int'(vecValid), 0);
    wr(3, 8'h01); cyc(1);
    chk(vecValid == 1 && vecIndex == 2, "R7 gie on presents", int'(vecIndex), 2);

    // R8: the acknowledge clears the pending bit and the global enable
    doAck();
    rd(0, r); chk(r == 8'h00, "R8 ack clears bit", int'(r), 0);
    rd(3, r); chk(r == 8'h00, "R8 ack clears gie", int'(r), 0);
    chk(vecValid == 0, "R8 valid drops", int'(vecValid), 0);

    // R6: a trap source runs without the global enable or programmed bits
    wr(1, 8'h00); wr(2, 8'h00);
    pulse(8'h01); cyc(2);
    chk(vecValid == 1 && vecIndex == 0, "R6 trap bypass", int'(vecValid), 1);
    doAck(); cyc(2);
    chk(vecValid == 0, "R6 trap acked", int'(vecValid), 0);

    // R12: the winner is held while a higher request arrives, until the acknowledge
    wr(1, 8'h04); wr(2, 8'h24); wr(3, 8'h01);
    pulse(8'h20); cyc(2);
    chk(vecIndex == 5, "R12 first winner", int'(vecIndex), 5);
    pulse(8'h04); cyc(3);
    chk(vecValid == 1 && vecIndex == 5, "R12 index held", int'(vecIndex), 5);
    doAck();
    rd(0, r); chk(r == 8'h04, "R8 only serviced bit cleared", int'(r), 4);
    wr(3, 8'h01); cyc(2);
    chk(vecValid == 1 && vecIndex == 2, "R12 next winner", int'(vecIndex), 2);

    // R9: a full write of 0 erases an unserviced request
    wr(0, 8'h00); cyc(2);
    rd(0, r); chk(r == 8'h00, "R9 write0 erases", int'(r), 0);
    chk(vecValid == 0, "R9 valid drops", int'(vecValid), 0);

    // R10: a pulse wins over a register clear in the same cycle
    pulse(8'h08);
    srcPulse = 8'h08; wr(0, 8'h00); srcPulse = '0;
    rd(0, r); chk(r == 8'h08, "R10 pulse over write", int'(r), 8);
    // R10: a pulse wins over an acknowledge of the same bit
    wr(1, 8'h08); wr(2, 8'h08); wr(3, 8'h01); cyc(2);
    chk(vecValid == 1 && vecIndex == 3, "R10 presenting 3", int'(vecIndex), 3);
    srcPulse = 8'h08; ack = 1'b1; cyc(1); srcPulse = '0; ack = 1'b0;
    rd(0, r); chk(r == 8'h08, "R10 pulse over ack", int'(r), 8);

    // R11: the global enable is set by a write of 1 and cleared by diStrobe or a write of 0
    wr(3, 8'h01); rd(3, r); chk(r == 8'h01, "R11 set gie", int'(r), 1);
    diStrobe = 1'b1; cyc(1); diStrobe = 1'b0;
    rd(3, r); chk(r == 8'h00, "R11 di clears", int'(r), 0);
    wr(3, 8'h01); wr(3, 8'h00);
    rd(3, r); chk(r == 8'h00, "R11 write0 clears", int'(r), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule